// File: doc/BRIEF.md
# Conditional-Carry Block-Select Adder

This block is a purely combinational binary adder. Its operands are cut into equal slices. Each slice looks only at its own operand bits and works out two candidate carry-outs. The first assumes no carry enters the slice. The second assumes a carry does enter. Each slice also forms the per-bit generate, transfer and propagate terms that this work needs.

The real carry into each slice is then settled one slice at a time, starting at the least significant slice. The external carry-in picks the bottom slice's candidate. Each slice's settled carry then picks the candidate of the slice above it. Sum bits are produced only after every slice carry is known. They are produced by rippling inside each slice from its settled carry-in.

The block has no clock, no storage and no handshake. It sits between registers in a datapath, and its result is valid one propagation delay after the operands settle. The default shape is 8 bits in four 2-bit slices. The total width must be a whole multiple of the slice width, and elaboration stops with an error otherwise.

Top module: `csel_adder`

## Requirements
- R1: For every operand pair and both carry-in values, {co_o, sum_o} equals op_a_i + op_b_i + ci_i as an unsigned sum of width WIDTH+1.
- R2: Each slice's no-carry candidate equals the carry-out of adding that slice's operand bits with a carry-in of 0.
- R3: Each slice's with-carry candidate equals the carry-out of adding that slice's operand bits with a carry-in of 1. Whenever the no-carry candidate is 1, the with-carry candidate is also 1.
- R4: The settled carry out of slice k equals the with-carry candidate when the carry into slice k is 1, and the no-carry candidate otherwise. The carry into slice 0 is ci_i.
- R5: A carry-in of 1 is added correctly: 0xFF + 0x00 + 1 gives sum 0x00 and co_o 1.
- R6: A carry generated in the bottom slice crosses every higher slice that only transfers: 0x01 + 0xFF gives sum 0x00 and co_o 1.
- R7: Sum bits use the exclusive-or of the operand bits, not the inclusive-or: 0xAA + 0xAA gives sum 0x54 and co_o 1.
- R8: co_o is the settled carry out of the top slice: 0x80 + 0x80 gives sum 0x00 and co_o 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | WIDTH | First operand |
| op_b_i | input | WIDTH | Second operand |
| ci_i | input | 1 | Carry into the least significant bit |
| sum_o | output | WIDTH | Sum bits |
| co_o | output | 1 | Carry out of the most significant bit |

## Verification
Whenever the inputs settle to known values, the assertions check each slice's two candidates against slice-level arithmetic. They also check that the no-carry candidate implies the with-carry candidate, that each settled slice carry equals the true carry of that slice given its incoming carry, and that the full-width result is exact. The bench cannot see the slice candidates. It can only show at the outputs that every 8-bit operand pair with both carry-in values gives the right sum and carry-out. Its directed cases aim at the corner patterns: a carry crossing transfer-only slices, inputs where exclusive-or and inclusive-or differ, and a carry-out produced only by the top slice.

// File: rtl/csel_adder_pkg.sv
package csel_adder_pkg;
  // Pair of candidate carries produced by one slice.
  typedef struct packed {
    logic c_one;   // carry-out assuming carry-in of 1
    logic c_zero;  // carry-out assuming carry-in of 0
  } cand_pair_t;
endpackage

// File: rtl/csel_bit_terms.sv
module csel_bit_terms (
  input  logic a_i,
  input  logic b_i,
  output logic gen_o,
  output logic tra_o,
  output logic prp_o
);
  assign gen_o = a_i & b_i;
  assign tra_o = a_i | b_i;
  assign prp_o = a_i ^ b_i;
endmodule

// File: rtl/csel_slice_cand.sv
module csel_slice_cand
  import csel_adder_pkg::*;
#(
  parameter int SLICE_W = 2
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  output logic [SLICE_W-1:0] gen_o,
  output logic [SLICE_W-1:0] tra_o,
  output logic [SLICE_W-1:0] prp_o,
  output cand_pair_t         cand_o
);
  for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
    csel_bit_terms u_terms (
      .a_i   (a_i[i]),
      .b_i   (b_i[i]),
      .gen_o (gen_o[i]),
      .tra_o (tra_o[i]),
      .prp_o (prp_o[i])
    );
  end

  // Group generate: ripple the generates with the slice carry-in held at 0.
  logic grp_gen;
  always_comb begin
    grp_gen = 1'b0;
    for (int i = 0; i < SLICE_W; i++) begin
      grp_gen = gen_o[i] | (tra_o[i] & grp_gen);
    end
  end

  // With-carry candidate: group generate or full-slice transfer, no second chain.
  assign cand_o.c_zero = grp_gen;
  assign cand_o.c_one  = grp_gen | (&tra_o);
endmodule

// File: rtl/csel_slice_sum.sv
module csel_slice_sum #(
  parameter int SLICE_W = 2
) (
  input  logic [SLICE_W-1:0] gen_i,
  input  logic [SLICE_W-1:0] tra_i,
  input  logic [SLICE_W-1:0] prp_i,
  input  logic               cin_i,
  output logic [SLICE_W-1:0] sum_o
);
  logic [SLICE_W:0] carry;

  assign carry[0] = cin_i;
  for (genvar i = 0; i < SLICE_W; i++) begin : g_rip
    assign carry[i+1] = gen_i[i] | (tra_i[i] & carry[i]);
    assign sum_o[i]   = prp_i[i] ^ carry[i];
  end
endmodule

// File: rtl/csel_adder.sv
module csel_adder
  import csel_adder_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int SLICE_W = 2
) (
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic             ci_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             co_o
);
  localparam int NSLICE = WIDTH / SLICE_W;

  if ((WIDTH % SLICE_W) != 0 || SLICE_W < 1) begin : g_bad_shape
    $error("csel_adder: WIDTH must be a positive multiple of SLICE_W");
  end

  logic [WIDTH-1:0]  gen_w, tra_w, prp_w;
  logic [NSLICE-1:0] cand_c0, cand_c1;
  logic [NSLICE:0]   slc_cin;   // slc_cin[k] enters slice k; slc_cin[k+1] leaves it

  assign slc_cin[0] = ci_i;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    cand_pair_t cand;

    csel_slice_cand #(.SLICE_W(SLICE_W)) u_cand (
      .a_i    (op_a_i[k*SLICE_W +: SLICE_W]),
      .b_i    (op_b_i[k*SLICE_W +: SLICE_W]),
      .gen_o  (gen_w[k*SLICE_W +: SLICE_W]),
      .tra_o  (tra_w[k*SLICE_W +: SLICE_W]),
      .prp_o  (prp_w[k*SLICE_W +: SLICE_W]),
      .cand_o (cand)
    );

    assign cand_c0[k] = cand.c_zero;
    assign cand_c1[k] = cand.c_one;

    // Serial selection from the bottom slice upward.
    assign slc_cin[k+1] = slc_cin[k] ? cand.c_one : cand.c_zero;

    // Deferred sum formation from the settled slice carry-in.
    csel_slice_sum #(.SLICE_W(SLICE_W)) u_sum (
      .gen_i (gen_w[k*SLICE_W +: SLICE_W]),
      .tra_i (tra_w[k*SLICE_W +: SLICE_W]),
      .prp_i (prp_w[k*SLICE_W +: SLICE_W]),
      .cin_i (slc_cin[k]),
      .sum_o (sum_o[k*SLICE_W +: SLICE_W])
    );
  end

  assign co_o = slc_cin[NSLICE];
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk #(
  parameter int WIDTH   = 8,
  parameter int SLICE_W = 2
) (
  input logic [WIDTH-1:0]          op_a_i,
  input logic [WIDTH-1:0]          op_b_i,
  input logic                      ci_i,
  input logic [WIDTH-1:0]          sum_o,
  input logic                      co_o,
  input logic [WIDTH/SLICE_W-1:0]  cand_c0,
  input logic [WIDTH/SLICE_W-1:0]  cand_c1,
  input logic [WIDTH/SLICE_W:0]    slc_cin
);
  localparam int NSLICE = WIDTH / SLICE_W;

  logic [WIDTH:0] full_ref;
  assign full_ref = {1'b0, op_a_i} + {1'b0, op_b_i} + {{WIDTH{1'b0}}, ci_i};

  always_comb begin
    if (!$isunknown({op_a_i, op_b_i, ci_i})) begin
      AST_EXACT_RESULT: assert ({co_o, sum_o} == full_ref); // R1
    end
  end

  for (genvar k = 0; k < NSLICE; k++) begin : g_chk
    logic [SLICE_W:0] ref0, ref1, refsel;
    assign ref0   = {1'b0, op_a_i[k*SLICE_W +: SLICE_W]} + {1'b0, op_b_i[k*SLICE_W +: SLICE_W]};
    assign ref1   = ref0 + {{SLICE_W{1'b0}}, 1'b1};
    assign refsel = ref0 + {{SLICE_W{1'b0}}, slc_cin[k]};

    always_comb begin
      if (!$isunknown({op_a_i, op_b_i, ci_i})) begin
        AST_CAND_ZERO: assert (cand_c0[k] == ref0[SLICE_W]); // R2
        AST_CAND_ONE: assert (cand_c1[k] == ref1[SLICE_W]); // R3
        AST_CAND_ORDER: assert (!(cand_c0[k] && !cand_c1[k])); // R3
        AST_SLICE_SELECT: assert (slc_cin[k+1] == refsel[SLICE_W]); // R4
      end
    end
  end
endmodule

bind csel_adder csel_adder_chk #(.WIDTH(WIDTH), .SLICE_W(SLICE_W)) u_chk (
  .op_a_i  (op_a_i),
  .op_b_i  (op_b_i),
  .ci_i    (ci_i),
  .sum_o   (sum_o),
  .co_o    (co_o),
  .cand_c0 (cand_c0),
  .cand_c1 (cand_c1),
  .slc_cin (slc_cin)
);

// File: tb/csel_adder_tb.sv
module csel_adder_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         ci = 1'b0;
  logic [W-1:0] sum;
  logic         co;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  csel_adder #(.WIDTH(W), .SLICE_W(2)) u_dut (
    .op_a_i (a),
    .op_b_i (b),
    .ci_i   (ci),
    .sum_o  (sum),
    .co_o   (co)
  );

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 190000", cycles);
      summary();
    end
  end

  // Behavioural reference: plain integer arithmetic.
  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb,
                       input logic vci, input string tag);
    int exp_v, got_v;
    @(posedge clk);
    #1;
    a = va; b = vb; ci = vci;
    @(negedge clk);
    exp_v = int'(va) + int'(vb) + int'(vci);
    got_v = int'({co, sum});
    n_cmp = n_cmp + 1;
    if (got_v != exp_v) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: a=%h b=%h ci=%0d got %h expected %h", tag, va, vb, vci, got_v, exp_v);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: zero inputs must give a zero result (R1)
    apply(8'h00, 8'h00, 1'b0, "R1 idle");
    // Directed corners
    apply(8'hFF, 8'h00, 1'b1, "R5");
    apply(8'h01, 8'hFF, 1'b0, "R6");
    apply(8'h55, 8'hAB, 1'b0, "R6");
    apply(8'hAA, 8'hAA, 1'b0, "R7");
    apply(8'h55, 8'h55, 1'b1, "R7");
    apply(8'h80, 8'h80, 1'b0, "R8");
    apply(8'hC0, 8'h40, 1'b1, "R8");
    apply(8'h03, 8'h01, 1'b0, "R2");
    apply(8'h03, 8'h0D, 1'b0, "R3");
    apply(8'h0C, 8'h03, 1'b1, "R3");
    apply(8'h3F, 8'h01, 1'b0, "R4");
    apply(8'h3F, 8'h00, 1'b1, "R4");
    apply(8'hFF, 8'hFF, 1'b1, "R1 max");
    // Random vectors
    for (int i = 0; i < 2000; i++) begin
      apply(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
    end
    // Exhaustive operands with both carry-in values (R1, R4)
    for (int c = 0; c < 2; c++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          apply(W'(x), W'(y), 1'(c), "R1 exhaustive");
        end
      end
    end
    summary();
  end
endmodule